// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sits between a simple register bus and the analog front end of a successive-approximation converter. Software selects one of eight inputs, sets the power bit, and the block then waits a programmable number of clocks for the analog section to settle. After that wait it runs a binary search, one bit per clock and most significant bit first. The search drives a trial code into an external DAC and reads back a comparator that reports whether the input is at or above that code.

When the last bit resolves, the code is stored in the result register, the busy flag drops and an interrupt-pending flag is set. That flag raises the interrupt line when the interrupt is enabled. Writing zero to the control register is the single action that acknowledges the interrupt and powers the converter down. Clearing the power bit during a conversion abandons the conversion.

Top module: `sar_seq_ctrl`

## Requirements
- R1: Byte offsets: 0x00 result, 0x04 status, 0x08 control, 0x0C settle delay. Any other offset reads as zero. Control layout: bits [2:0] input select, bit 3 power, bit 5 interrupt enable, bit 6 interrupt pending, all other bits read zero. The delay register keeps only its low 6 bits. The input select appears on `adc_chan` and the power bit on `adc_pwr`.
- R2: A control write with bit 3 set loads the delay value D. The search starts D+1 clocks after that write. During the wait `dac_code` is 0, and in the first search cycle it is the MSB alone.
- R3: The search settles one bit per clock from MSB to LSB. A trial bit is kept when `cmp_ge` is 1. The final code equals min(input, 2^RES-1). `dac_code` is zero whenever no search is running.
- R4: In the clock after the LSB trial, the result register holds the new code, busy is 0 and interrupt pending is 1.
- R5: `irq` is 1 exactly while interrupt pending and interrupt enable are both 1.
- R6: A control write clears interrupt pending when its bit 6 is 0 and leaves it unchanged when bit 6 is 1. It never sets the flag. Writing zero therefore acknowledges the interrupt and powers the converter down.
- R7: A control write with bit 3 clear during a wait or search returns the block to idle in the next clock, and the result register keeps its old value.
- R8: The result register holds its value until the next completed search. It is right-justified, with the bits above RES reading zero.
- R9: After reset the result, status and control registers read 0 and the delay register reads 8.
- R10: Status bit 0 reads 1 from the clock after a start write until the search completes or is aborted.
- R11: A control write with bit 3 set during a wait or search restarts the sequence from the delay phase, using the newly written input select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from address |
| cmp_ge | input | 1 | Comparator: input is at or above `dac_code` |
| dac_code | output | RES | Trial code for the DAC |
| adc_chan | output | 3 | Selected analog input |
| adc_pwr | output | 1 | Converter power enable |
| irq | output | 1 | Interrupt request |

## Verification
The comparator model holds a separate analog level for each of the eight inputs. Each conversion therefore also checks that the right input was routed.

The levels are chosen to separate specific faults:
- 0 and full scale catch a search that starts or stops one bit off.
- 511 and 512 separate the MSB keep/drop decision.
- A level above full scale checks clipping.

Delays of 0, 3 and 63 expose off-by-one errors in the settle counter. Aborts and restarts in the middle of a search check that the result register and the interrupt flag are left alone.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_STAT = 4;
  localparam int unsigned OFS_CTRL = 8;
  localparam int unsigned OFS_DLY  = 12;

  localparam int CHAN_W   = 3;
  localparam int BIT_PWR  = 3;
  localparam int BIT_IEN  = 5;
  localparam int BIT_IST  = 6;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_CONV = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_delay_timer.sv
module sar_delay_timer #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (run && !zero)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sar_search_engine.sv
module sar_search_engine
  import sar_seq_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           stop,
  input  logic           wait_zero,
  input  logic           cmp_ge,
  output logic           in_wait,
  output logic           busy,
  output logic           done,
  output logic [RES-1:0] result,
  output logic [RES-1:0] dac_code,
  output logic [RES-1:0] mask
);
  localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

  phase_e         phase_q;
  logic [RES-1:0] acc_q;
  logic [RES-1:0] mask_q;

  function automatic logic [RES-1:0] trial_of(input logic [RES-1:0] acc,
                                               input logic [RES-1:0] bitm);
    return acc | bitm;
  endfunction

  function automatic logic [RES-1:0] settle(input logic [RES-1:0] acc,
                                            input logic [RES-1:0] bitm,
                                            input logic           ge);
    return ge ? (acc | bitm) : acc;
  endfunction

  always_comb begin
    in_wait  = (phase_q == PH_WAIT);
    busy     = (phase_q != PH_IDLE);
    result   = settle(acc_q, mask_q, cmp_ge);
    done     = (phase_q == PH_CONV) && mask_q[0] && !start && !stop;
    dac_code = (phase_q == PH_CONV) ? trial_of(acc_q, mask_q) : '0;
    mask     = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      acc_q   <= '0;
      mask_q  <= '0;
    end else if (start) begin
      phase_q <= PH_WAIT;
      acc_q   <= '0;
      mask_q  <= '0;
    end else if (stop) begin
      phase_q <= PH_IDLE;
      mask_q  <= '0;
    end else begin
      case (phase_q)
        PH_WAIT: if (wait_zero) begin
          phase_q <= PH_CONV;
          acc_q   <= '0;
          mask_q  <= MSB_ONLY;
        end
        PH_CONV: begin
          acc_q  <= result;
          mask_q <= mask_q >> 1;
          if (mask_q[0]) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_reg_bank.sv
module sar_reg_bank
  import sar_seq_pkg::*;
#(
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int RES     = 10,
  parameter int DLY_W   = 6,
  parameter int DLY_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [RES-1:0]    result,
  output logic [CHAN_W-1:0] chan,
  output logic              pwr,
  output logic              ien,
  output logic              ist,
  output logic [DLY_W-1:0]  dly,
  output logic [RES-1:0]    data_q,
  output logic              start,
  output logic              stop
);
  logic ctrl_wr, dly_wr;
  logic wdata_unused;

  assign wdata_unused = ^bus_wdata[DW-1:BIT_IST+1];
  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == AW'(OFS_CTRL));
  assign dly_wr  = bus_sel && bus_wr && (bus_addr == AW'(OFS_DLY));
  assign start   = ctrl_wr &&  bus_wdata[BIT_PWR];
  assign stop    = ctrl_wr && !bus_wdata[BIT_PWR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan <= '0;
      pwr  <= 1'b0;
      ien  <= 1'b0;
      ist  <= 1'b0;
    end else if (ctrl_wr) begin
      chan <= bus_wdata[CHAN_W-1:0];
      pwr  <= bus_wdata[BIT_PWR];
      ien  <= bus_wdata[BIT_IEN];
      ist  <= ist & bus_wdata[BIT_IST];
    end else if (done) begin
      ist  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly <= DLY_W'(DLY_RST);
    else if (dly_wr) dly <= bus_wdata[DLY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (done) data_q <= result;
  end

  always_comb begin
    case (bus_addr)
      AW'(OFS_DATA): bus_rdata = DW'(data_q);
      AW'(OFS_STAT): bus_rdata = DW'(busy);
      AW'(OFS_CTRL): bus_rdata = DW'({ist, ien, 1'b0, pwr, chan});
      AW'(OFS_DLY):  bus_rdata = DW'(dly);
      default:       bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES     = 10,
  parameter int DLY_W   = 6,
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter int DLY_RST = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           cmp_ge,
  output logic [RES-1:0] dac_code,
  output logic [2:0]     adc_chan,
  output logic           adc_pwr,
  output logic           irq
);
  logic              seq_start, seq_stop, seq_busy, seq_done, seq_wait, wait_zero;
  logic              ctl_ien, ctl_ist, ctl_pwr;
  logic [CHAN_W-1:0] ctl_chan;
  logic [DLY_W-1:0]  ctl_dly;
  logic [RES-1:0]    seq_result, seq_mask, res_q;
  logic              ctl_wr_any;

  sar_reg_bank #(.AW(AW), .DW(DW), .RES(RES), .DLY_W(DLY_W), .DLY_RST(DLY_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(seq_busy), .done(seq_done), .result(seq_result),
    .chan(ctl_chan), .pwr(ctl_pwr), .ien(ctl_ien), .ist(ctl_ist),
    .dly(ctl_dly), .data_q(res_q), .start(seq_start), .stop(seq_stop)
  );

  sar_delay_timer #(.DLY_W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(seq_start), .load_val(ctl_dly),
    .run(seq_wait), .zero(wait_zero)
  );

  sar_search_engine #(.RES(RES)) u_search (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .stop(seq_stop),
    .wait_zero(wait_zero), .cmp_ge(cmp_ge), .in_wait(seq_wait),
    .busy(seq_busy), .done(seq_done), .result(seq_result),
    .dac_code(dac_code), .mask(seq_mask)
  );

  assign ctl_wr_any = seq_start | seq_stop;
  assign adc_chan   = ctl_chan;
  assign adc_pwr    = ctl_pwr;
  assign irq        = ctl_ist & ctl_ien;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           start,
  input logic           stop,
  input logic           ctrl_wr,
  input logic [RES-1:0] dac_code,
  input logic [RES-1:0] mask,
  input logic [RES-1:0] result,
  input logic [RES-1:0] data_q,
  input logic           ist,
  input logic           ien,
  input logic           irq
);
  assert_dac_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0));

  assert_single_trial_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask));

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  assert_done_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && ist));

  assert_done_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (data_q == $past(result)));

  assert_abort_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && busy) |=> (!busy && data_q == $past(data_q)));

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done) || $past(ctrl_wr)));

  assert_irq_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien);
endmodule

bind sar_seq_ctrl sar_seq_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(seq_busy), .done(seq_done),
  .start(seq_start), .stop(seq_stop), .ctrl_wr(ctl_wr_any),
  .dac_code(dac_code), .mask(seq_mask), .result(seq_result),
  .data_q(res_q), .ist(ctl_ist), .ien(ctl_ien), .irq(irq)
);

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
  localparam int RES = 10, AW = 5, DW = 32, FULL = (1 << RES) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic cmp_ge, adc_pwr, irq;
  logic [RES-1:0] dac_code;
  logic [2:0] adc_chan;
  int vin [8];
  int n_chk = 0, n_fail = 0, cyc = 0, cur_dly = 8;
  bit run_cmp = 0;

  always #10 clk = ~clk;

  sar_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_ge(cmp_ge), .dac_code(dac_code), .adc_chan(adc_chan),
    .adc_pwr(adc_pwr), .irq(irq)
  );

  assign cmp_ge = vin[adc_chan] >= int'({22'b0, dac_code});

  // behavioural reference: st 0 idle, 1 settle wait, 2 search
  int m_st, m_cnt, m_acc, m_bit, m_data, m_ist, m_ien, m_pwr, m_chan, m_dly;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_acc = 0; m_bit = 0; m_data = 0;
      m_ist = 0; m_ien = 0; m_pwr = 0; m_chan = 0; m_dly = 8;
    end else begin
      if (bus_sel && bus_wr && bus_addr == 8) begin
        m_chan = bus_wdata & 7; m_pwr = bus_wdata[3]; m_ien = bus_wdata[5];
        m_ist = m_ist & bus_wdata[6];
        if (m_pwr != 0) begin m_st = 1; m_cnt = m_dly; end else m_st = 0;
      end else if (m_st == 1) begin
        if (m_cnt == 0) begin m_st = 2; m_bit = RES - 1; m_acc = 0; end
        else m_cnt = m_cnt - 1;
      end else if (m_st == 2) begin
        if (vin[m_chan] >= (m_acc | (1 << m_bit))) m_acc = m_acc | (1 << m_bit);
        if (m_bit == 0) begin m_data = m_acc; m_ist = 1; m_st = 0; end
        else m_bit = m_bit - 1;
      end
      if (bus_sel && bus_wr && bus_addr == 12) m_dly = bus_wdata & 63;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (run_cmp) begin
    chk("R3 dac_code per cycle", int'(dac_code), (m_st == 2) ? (m_acc | (1 << m_bit)) : 0);
    chk("R5 irq per cycle", int'(irq), m_ist & m_ien);
    chk("R6 adc_pwr per cycle", int'(adc_pwr), m_pwr);
    chk("R1 adc_chan per cycle", int'(adc_chan), m_chan);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
    #2 v = int'(bus_rdata);
    bus_sel = 0;
  endtask

  task automatic set_dly(input int d);
    wr(12, d); cur_dly = d & 63;
  endtask

  // start, check settle timing, finish, check result
  task automatic run_conv(input int ch, input bit ie);
    int v;
    int expv = (vin[ch] > FULL) ? FULL : vin[ch];
    wr(8, 8 | (int'(ie) << 5) | ch);
    repeat (cur_dly) @(negedge clk);
    chk("R2 dac zero at end of wait", int'(dac_code), 0);
    @(negedge clk);
    chk("R2 first trial is MSB", int'(dac_code), 1 << (RES - 1));
    repeat (RES) @(negedge clk);
    chk("R4 irq after completion", int'(irq), int'(ie));
    rd(4, v); chk("R4 busy clear after search", v, 0);
    rd(0, v); chk("R3 result code", v, expv);
    rd(8, v); chk("R4 pending flag set", (v >> 6) & 1, 1);
  endtask

  initial begin
    int v;
    vin[0] = 0;   vin[1] = 512; vin[2] = 700; vin[3] = 511;
    vin[4] = 900; vin[5] = 341; vin[6] = 300; vin[7] = 5000;
    repeat (3) @(negedge clk);
    rst_n = 1; run_cmp = 1;

    rd(0, v);  chk("R9 result after reset", v, 0);
    rd(4, v);  chk("R9 status after reset", v, 0);
    rd(8, v);  chk("R9 control after reset", v, 0);
    rd(12, v); chk("R9 delay after reset", v, 8);
    rd(16, v); chk("R1 undefined 0x10", v, 0);
    rd(2, v);  chk("R1 undefined 0x02", v, 0);
    rd(28, v); chk("R1 undefined 0x1C", v, 0);
    set_dly(127); rd(12, v); chk("R1 delay keeps 6 bits", v, 63);

    set_dly(3);
    run_conv(2, 1);
    rd(8, v); chk("R1 control layout", v, 32'h6A);
    chk("R5 irq with enable", int'(irq), 1);
    wr(8, 32'h60); rd(8, v); chk("R6 pending kept by bit6=1", v, 32'h60);
    chk("R6 power off", int'(adc_pwr), 0);
    wr(8, 0); rd(8, v); chk("R6 zero write clears", v, 0);
    chk("R6 irq cleared", int'(irq), 0);
    rd(0, v); chk("R8 result held", v, 700);

    run_conv(0, 0);
    chk("R5 no irq without enable", int'(irq), 0);
    run_conv(7, 0);
    rd(0, v); chk("R8 upper bits zero at full scale", v >> RES, 0);
    run_conv(1, 0);
    run_conv(3, 1);
    set_dly(0);  run_conv(5, 1);
    set_dly(63); run_conv(6, 0);

    // busy flag during the wait
    wr(8, 8 | 1);
    rd(4, v); chk("R10 busy during wait", v, 1);
    repeat (cur_dly + RES + 2) @(negedge clk);
    rd(4, v); chk("R10 busy cleared", v, 0);

    // abort mid-search
    set_dly(3);
    wr(8, 0);
    rd(0, v); chk("R8 prior result", v, 512);
    wr(8, 8 | 32 | 6);
    repeat (cur_dly + 5) @(negedge clk);
    wr(8, 32);
    rd(4, v); chk("R7 idle after abort", v, 0);
    rd(0, v); chk("R7 result untouched", v, 512);
    rd(8, v); chk("R7 no pending after abort", v, 32'h20);
    chk("R7 dac quiet", int'(dac_code), 0);

    // restart mid-search on another input
    wr(8, 8 | 1);
    repeat (cur_dly + 4) @(negedge clk);
    run_conv(4, 1);
    rd(0, v); chk("R11 restart uses new input", v, 900);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule